// File: doc/BRIEF.md
# I2C Target Memory Protocol Engine

This block is the serial front end of a byte-wide nonvolatile memory. It watches the two wires of an I2C bus through synchronizers and a spike filter, recognises Start and Stop, and answers as a target at one fixed 7-bit select code. A write transaction carries a 16-bit memory address in two bytes and then any number of data bytes. Each data byte is handed to a separate page-buffer block together with its address. A Stop placed right after a data byte's acknowledge tells that block to start its write cycle.

Reads are served from a persistent address counter. A random read loads the counter with a dummy write followed by a repeated Start. A current-address read uses whatever the counter holds. Sequential reads go on for as long as the host acknowledges. While the page-buffer block reports busy, the engine stays off the bus, so a host can poll with the select code until it gets an acknowledge. The data line is driven only through an active-high pull-low enable. That enable changes a programmable number of system clocks after SCL falls.

Top module: `i2c_target_engine`

## Requirements
- R1: While rst_n is low and right after its release, sda_pull_o is 0, wr_valid_o and wr_commit_o are 0, and the address counter (rd_addr_o) is 0.
- R2: A Start is an SDA fall while SCL is high, and a Stop is an SDA rise while SCL is high. Bits are sampled on SCL rising edges, MSB first. A select byte whose bits 7..1 are 1010001 is acknowledged by pulling SDA low during the ninth clock. So 0xA2 selects a write (bit 0 = 0) and 0xA3 selects a read (bit 0 = 1).
- R3: A select byte with any other upper seven bits is not acknowledged. Every clock after it is ignored, with SDA left released, until the next Start.
- R4: In a write, the high address byte comes first and the low byte second, and both are acknowledged. The counter is loaded with the low ARRAY_AW bits of that 16-bit value. Each following data byte is acknowledged and presented once on wr_valid_o with wr_addr_o equal to the counter and wr_data_o equal to the byte. The counter then advances.
- R5: wr_commit_o pulses for one cycle only when a Stop follows directly after the acknowledge of a data byte. A Stop at any other point of a write gives no pulse.
- R6: A random read (0xA2, two address bytes, repeated Start, 0xA3) returns the byte stored at the loaded address.
- R7: A current-address read (Start, 0xA3) returns the byte at the counter. The counter advances by one after each byte read and after each byte written.
- R8: While the host acknowledges read bytes, consecutive bytes follow. After address 2^ARRAY_AW-1 the counter wraps to 0.
- R9: When the host does not acknowledge a read byte, the engine releases SDA and keeps it released for all later clocks until the next Start.
- R10: While busy_i is high, Start is ignored, nothing is acknowledged and SDA stays released.
- R11: A pulse shorter than GLITCH_CYC system clocks on SCL or SDA has no effect on the protocol.
- R12: sda_pull_o changes only while SCL is low, HOLD_CYC+1 clocks after the engine decides a new level on an SCL fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 20 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw SCL level from the pad |
| sda_i | input | 1 | Raw SDA level from the pad (wired bus value) |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| busy_i | input | 1 | Write cycle in progress in the page-buffer block |
| rd_addr_o | output | ARRAY_AW | Address counter, used as read address |
| rd_data_i | input | 8 | Byte stored at rd_addr_o |
| wr_valid_o | output | 1 | One-cycle strobe for a received data byte |
| wr_addr_o | output | ARRAY_AW | Address of the received data byte |
| wr_data_o | output | 8 | Received data byte |
| wr_commit_o | output | 1 | One-cycle pulse: start the write cycle |

## Verification
The bench goes after the wrap of a sequential read from the top address to 0. An engine whose counter is as wide as the whole address, or that advances at the wrong time, returns the wrong byte there or on the current-address read that follows. It places Stops both right after a data acknowledge and in the middle of a byte. A commit decoded on the wrong slot either loses a write or starts a write cycle on a torn byte. It also issues a mismatching select, a host NACK followed by more clocks, and polling while busy, where a careless engine keeps pulling SDA or answers a poll too early. Finally, it injects sub-threshold spikes on both lines inside an address byte. A weak filter turns these into extra bits or into a false Start/Stop, and the write then goes unacknowledged.

// File: rtl/i2c_target_pkg.sv
package i2c_target_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_RDAT
  } eng_state_t;

  localparam logic [6:0] SEL_CODE = 7'b1010001;

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int GLITCH_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  localparam int CW = $clog2(GLITCH_CYC + 1);

  logic          sync1_q;
  logic          sync2_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          out_d;

  always_comb begin
    cnt_d = cnt_q;
    out_d = line_o;
    if (sync2_q == line_o) begin
      cnt_d = '0;
    end else if (cnt_q == CW'(GLITCH_CYC - 1)) begin
      out_d = sync2_q;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
      cnt_q   <= '0;
      line_o  <= 1'b1;
    end else begin
      sync1_q <= line_i;
      sync2_q <= sync1_q;
      cnt_q   <= cnt_d;
      line_o  <= out_d;
    end
  end
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  always_comb begin
    scl_rise_o = scl_f & ~scl_q;
    scl_fall_o = ~scl_f & scl_q;
    start_o    = scl_f & scl_q & sda_q & ~sda_f;
    stop_o     = scl_f & scl_q & ~sda_q & sda_f;
  end
endmodule

// File: rtl/i2c_addr_counter.sv
module i2c_addr_counter #(
  parameter int ARRAY_AW = 13
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic [ARRAY_AW-1:0] load_val_i,
  input  logic                step_i,
  output logic [ARRAY_AW-1:0] addr_o
);
  logic [ARRAY_AW-1:0] addr_d;
  logic                addr_en;

  always_comb begin
    addr_en = load_i | step_i;
    if (load_i) addr_d = load_val_i;
    else        addr_d = addr_o + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_o <= '0;
    else if (addr_en) addr_o <= addr_d;
  end
endmodule

// File: rtl/i2c_sda_driver.sv
module i2c_sda_driver #(
  parameter int HOLD_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic pull_o
);
  localparam int HW = (HOLD_CYC > 0) ? $clog2(HOLD_CYC + 1) : 1;

  logic [HW-1:0] cnt_q;
  logic [HW-1:0] cnt_d;
  logic          pull_d;

  always_comb begin
    cnt_d  = cnt_q;
    pull_d = pull_o;
    if (req_i == pull_o) begin
      cnt_d = '0;
    end else if (cnt_q == HW'(HOLD_CYC)) begin
      pull_d = req_i;
      cnt_d  = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pull_o <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pull_o <= pull_d;
    end
  end
endmodule

// File: rtl/i2c_target_engine.sv
module i2c_target_engine
  import i2c_target_pkg::*;
#(
  parameter int ARRAY_AW   = 13,
  parameter int GLITCH_CYC = 3,
  parameter int HOLD_CYC   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_i,
  input  logic                sda_i,
  output logic                sda_pull_o,
  input  logic                busy_i,
  output logic [ARRAY_AW-1:0] rd_addr_o,
  input  logic [7:0]          rd_data_i,
  output logic                wr_valid_o,
  output logic [ARRAY_AW-1:0] wr_addr_o,
  output logic [7:0]          wr_data_o,
  output logic                wr_commit_o
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_v;
  logic [NLINES-1:0] filt_v;
  logic scl_f, sda_f;
  logic scl_rise, scl_fall, start_ev, stop_ev;

  eng_state_t st_q, st_d;
  logic [3:0] bit_q, bit_d;
  logic [7:0] sh_q, sh_d;
  logic [7:0] tx_q, tx_d;
  logic [7:0] ahi_q, ahi_d;
  logic       rw_q, rw_d;
  logic       mack_q, mack_d;
  logic       drv_q, drv_d;
  logic       dat_q, dat_d;
  logic       wr_valid_d, wr_commit_d;
  logic [ARRAY_AW-1:0] wr_addr_d;
  logic [7:0] wr_data_d;
  logic       cnt_load, cnt_step;
  logic [ARRAY_AW-1:0] cur_addr;
  logic [2:0] tx_idx;

  assign raw_v = {scl_i, sda_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    i2c_line_filter #(.GLITCH_CYC(GLITCH_CYC)) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (raw_v[g]),
      .line_o (filt_v[g])
    );
  end

  assign scl_f = filt_v[1];
  assign sda_f = filt_v[0];

  i2c_bus_events u_events (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_f      (scl_f),
    .sda_f      (sda_f),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_ev),
    .stop_o     (stop_ev)
  );

  i2c_addr_counter #(.ARRAY_AW(ARRAY_AW)) u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (cnt_load),
    .load_val_i (ARRAY_AW'({ahi_q, sh_q})),
    .step_i     (cnt_step),
    .addr_o     (cur_addr)
  );

  i2c_sda_driver #(.HOLD_CYC(HOLD_CYC)) u_drv (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (drv_q),
    .pull_o (sda_pull_o)
  );

  assign rd_addr_o = cur_addr;
  assign tx_idx    = 3'd7 - bit_q[2:0];

  always_comb begin
    st_d        = st_q;
    bit_d       = bit_q;
    sh_d        = sh_q;
    tx_d        = tx_q;
    ahi_d       = ahi_q;
    rw_d        = rw_q;
    mack_d      = mack_q;
    drv_d       = drv_q;
    dat_d       = dat_q;
    wr_valid_d  = 1'b0;
    wr_addr_d   = wr_addr_o;
    wr_data_d   = wr_data_o;
    wr_commit_d = 1'b0;
    cnt_load    = 1'b0;
    cnt_step    = 1'b0;

    if (stop_ev) begin
      // commit only on the slot right after a data acknowledge
      if (st_q == ST_WDAT && dat_q && bit_q == 4'd1) wr_commit_d = 1'b1;
      st_d  = ST_IDLE;
      drv_d = 1'b0;
      bit_d = '0;
      dat_d = 1'b0;
    end else if (start_ev) begin
      drv_d = 1'b0;
      bit_d = '0;
      dat_d = 1'b0;
      st_d  = busy_i ? ST_IDLE : ST_SEL;
    end else if (st_q != ST_IDLE) begin
      if (scl_rise) begin
        if (bit_q < 4'd8) sh_d = {sh_q[6:0], sda_f};
        else              mack_d = ~sda_f;
        if (bit_q < 4'd9) bit_d = bit_q + 1'b1;
      end else if (scl_fall) begin
        if (bit_q == 4'd8) begin
          // acknowledge slot begins
          unique case (st_q)
            ST_SEL: begin
              if (sh_q[7:1] == SEL_CODE && !busy_i) begin
                drv_d = 1'b1;
                rw_d  = sh_q[0];
              end else begin
                st_d  = ST_IDLE;
                drv_d = 1'b0;
              end
            end
            ST_AHI: begin
              drv_d = ~busy_i;
              ahi_d = sh_q;
            end
            ST_ALO: begin
              drv_d    = ~busy_i;
              cnt_load = 1'b1;
            end
            ST_WDAT: begin
              drv_d      = ~busy_i;
              wr_valid_d = 1'b1;
              wr_addr_d  = cur_addr;
              wr_data_d  = sh_q;
              cnt_step   = 1'b1;
              dat_d      = 1'b1;
            end
            ST_RDAT: drv_d = 1'b0;
            default: drv_d = 1'b0;
          endcase
        end else if (bit_q == 4'd9) begin
          // acknowledge slot ends
          bit_d = '0;
          unique case (st_q)
            ST_SEL: begin
              if (rw_q) begin
                st_d     = ST_RDAT;
                tx_d     = rd_data_i;
                drv_d    = ~rd_data_i[7];
                cnt_step = 1'b1;
              end else begin
                st_d  = ST_AHI;
                drv_d = 1'b0;
              end
            end
            ST_AHI: begin
              st_d  = ST_ALO;
              drv_d = 1'b0;
            end
            ST_ALO: begin
              st_d  = ST_WDAT;
              drv_d = 1'b0;
            end
            ST_WDAT: drv_d = 1'b0;
            ST_RDAT: begin
              if (mack_q) begin
                tx_d     = rd_data_i;
                drv_d    = ~rd_data_i[7];
                cnt_step = 1'b1;
              end else begin
                st_d  = ST_IDLE;
                drv_d = 1'b0;
              end
            end
            default: drv_d = 1'b0;
          endcase
        end else if (st_q == ST_RDAT && bit_q != 4'd0) begin
          drv_d = ~tx_q[tx_idx];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      bit_q       <= '0;
      sh_q        <= '0;
      tx_q        <= '0;
      ahi_q       <= '0;
      rw_q        <= 1'b0;
      mack_q      <= 1'b0;
      drv_q       <= 1'b0;
      dat_q       <= 1'b0;
      wr_valid_o  <= 1'b0;
      wr_addr_o   <= '0;
      wr_data_o   <= '0;
      wr_commit_o <= 1'b0;
    end else begin
      st_q        <= st_d;
      bit_q       <= bit_d;
      sh_q        <= sh_d;
      tx_q        <= tx_d;
      ahi_q       <= ahi_d;
      rw_q        <= rw_d;
      mack_q      <= mack_d;
      drv_q       <= drv_d;
      dat_q       <= dat_d;
      wr_valid_o  <= wr_valid_d;
      wr_addr_o   <= wr_addr_d;
      wr_data_o   <= wr_data_d;
      wr_commit_o <= wr_commit_d;
    end
  end
endmodule

// File: rtl/i2c_target_checks.sv
module i2c_target_checks
  import i2c_target_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       busy_i,
  input logic       scl_f,
  input logic       sda_pull_o,
  input logic       drv_q,
  input eng_state_t st_q,
  input logic       wr_valid_o,
  input logic       wr_commit_o
);
  AST_PULL_ON_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull_o != $past(sda_pull_o)) |-> !scl_f); // R12

  AST_IDLE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && st_q == ST_IDLE) |=> (st_q == ST_IDLE)); // R10

  AST_RELEASE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && st_q == ST_IDLE) |-> !drv_q); // R10

  AST_WR_IN_DATA_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> (st_q == ST_WDAT)); // R4

  AST_COMMIT_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit_o |-> (!wr_valid_o && st_q == ST_IDLE)); // R5

  AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit_o |=> !wr_commit_o); // R5
endmodule

bind i2c_target_engine i2c_target_checks u_checks (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy_i      (busy_i),
  .scl_f       (scl_f),
  .sda_pull_o  (sda_pull_o),
  .drv_q       (drv_q),
  .st_q        (st_q),
  .wr_valid_o  (wr_valid_o),
  .wr_commit_o (wr_commit_o)
);

// File: tb/test_i2c_target_engine.sv
module test_i2c_target_engine;
  localparam int CLK_PERIOD = 10;
  localparam int AW         = 13;
  localparam int GLITCH     = 3;
  localparam int HOLD       = 4;
  localparam int Q          = 16;
  localparam int BUSY_CYC   = 900;
  localparam int DEPTH      = 1 << AW;
  localparam int NVEC       = 6;
  // {address[15:0], data[7:0]}
  localparam logic [23:0] VEC [NVEC] = '{
    {16'h0010, 8'hA5}, {16'h1FFF, 8'h3C}, {16'hE123, 8'h77},
    {16'h0000, 8'h00}, {16'h0AB5, 8'hFF}, {16'h1234, 8'h81}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_h = 1'b1;
  logic sda_h = 1'b1;
  logic sda_pull, wr_valid, wr_commit, busy;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [7:0] rd_data, wr_data;
  wire sda_line = sda_h & ~sda_pull;

  logic [7:0] mem  [DEPTH];
  logic [7:0] emem [DEPTH];
  int busy_cnt = 0;
  int commits = 0, pulls = 0, viol = 0;
  int n_chk = 0, n_err = 0;
  logic prev_pull = 1'b0;
  logic [AW-1:0] last_wa = '0;
  logic [7:0] last_wd = '0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_target_engine #(.ARRAY_AW(AW), .GLITCH_CYC(GLITCH), .HOLD_CYC(HOLD)) i_i2c_target_engine (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_h), .sda_i(sda_line), .sda_pull_o(sda_pull),
    .busy_i(busy), .rd_addr_o(rd_addr), .rd_data_i(rd_data), .wr_valid_o(wr_valid),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_commit_o(wr_commit)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'(a) ^ 8'(a >> 8) ^ 8'hC3;
  endfunction

  assign busy    = (busy_cnt != 0);
  assign rd_data = mem[rd_addr];

  // memory / page buffer model and monitors
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= pat(i);
    end else begin
      if (wr_valid) begin
        mem[wr_addr] <= wr_data;
        last_wa <= wr_addr;
        last_wd <= wr_data;
      end
      if (wr_commit) begin
        commits  <= commits + 1;
        busy_cnt <= BUSY_CYC;
      end else if (busy_cnt != 0) begin
        busy_cnt <= busy_cnt - 1;
      end
      if (sda_pull) pulls <= pulls + 1;
      if (sda_pull != prev_pull && scl_h) viol <= viol + 1;
      prev_pull <= sda_pull;
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clk_bit(input logic b, input bit glitch, output logic got);
    wt(2);
    sda_h = b;
    wt(4);
    if (glitch) begin scl_h = 1'b1; wt(GLITCH-1); scl_h = 1'b0; end
    wt(Q - 6 - (glitch ? GLITCH-1 : 0));
    scl_h = 1'b1;
    wt(2);
    if (glitch && b) begin sda_h = 1'b0; wt(GLITCH-1); sda_h = 1'b1; end
    wt(Q/2 - 2 - ((glitch && b) ? GLITCH-1 : 0));
    got = sda_line;
    wt(Q/2);
    scl_h = 1'b0;
  endtask

  task automatic i2c_start();
    wt(Q);
    sda_h = 1'b1; wt(Q);
    scl_h = 1'b1; wt(Q);
    sda_h = 1'b0; wt(Q);
    scl_h = 1'b0;
  endtask

  task automatic i2c_stop();
    wt(2);
    sda_h = 1'b0; wt(Q);
    scl_h = 1'b1; wt(Q);
    sda_h = 1'b1; wt(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch, output logic ack);
    logic g;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], glitch, g);
    clk_bit(1'b1, 1'b0, g);
    ack = ~g;
  endtask

  task automatic recv_byte(input bit host_ack, output logic [7:0] d);
    logic g;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      clk_bit(1'b1, 1'b0, g);
      d = {d[6:0], g};
    end
    clk_bit(~host_ack, 1'b0, g);
  endtask

  task automatic poll(output int tries);
    logic k;
    tries = 0;
    k = 1'b0;
    while (!k && tries < 40) begin
      i2c_start();
      send_byte(8'hA2, 0, k);
      i2c_stop();
      tries++;
    end
  endtask

  task automatic rd_check(input logic [15:0] a, input int n, input string req);
    logic k;
    logic [7:0] d;
    i2c_start();
    send_byte(8'hA2, 0, k); chk({req, " dummy-write select ack (R2)"}, k, 1);
    send_byte(a[15:8], 0, k); chk({req, " addr hi ack"}, k, 1);
    send_byte(a[7:0], 0, k);  chk({req, " addr lo ack"}, k, 1);
    i2c_start();
    send_byte(8'hA3, 0, k); chk({req, " read select ack (R2)"}, k, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n-1, d);
      chk(req, d, emem[(int'(a) + i) % DEPTH]);
    end
    i2c_stop();
  endtask

  task automatic cur_read(output logic [7:0] d);
    logic k;
    i2c_start();
    send_byte(8'hA3, 0, k); chk("R2 current read select ack", k, 1);
    recv_byte(0, d);
    i2c_stop();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic k, g;
    logic [7:0] d;
    logic [15:0] a;
    logic [7:0] dv;
    int tries, c0, p0;

    for (int i = 0; i < DEPTH; i++) emem[i] = pat(i);

    // R1: reset state
    wt(5);
    chk("R1 pull in reset", sda_pull, 0);
    chk("R1 wr_valid in reset", wr_valid, 0);
    chk("R1 commit in reset", wr_commit, 0);
    chk("R1 counter in reset", rd_addr, 0);
    rst_n = 1'b1;
    wt(20);
    chk("R1 pull after reset", sda_pull, 0);

    // table: byte write, poll, random read
    for (int v = 0; v < NVEC; v++) begin
      a  = VEC[v][23:8];
      dv = VEC[v][7:0];
      c0 = commits;
      i2c_start();
      send_byte(8'hA2, 0, k); chk("R2 write select ack", k, 1);
      send_byte(a[15:8], 0, k); chk("R4 addr hi ack", k, 1);
      send_byte(a[7:0], 0, k);  chk("R4 addr lo ack", k, 1);
      send_byte(dv, 0, k);      chk("R4 data ack", k, 1);
      wt(2);
      chk("R4 wr_addr", last_wa, a[AW-1:0]);
      chk("R4 wr_data", last_wd, dv);
      i2c_stop();
      wt(4);
      chk("R5 commit after data stop", commits, c0 + 1);
      emem[a[AW-1:0]] = dv;
      poll(tries);
      chk("R10 first poll refused", tries > 1, 1);
      chk("R10 poll finally accepted", tries < 40, 1);
      rd_check(a, 1, "R6");
    end

    // R7: current address after last random read (0x1234 -> 0x1235)
    cur_read(d);
    chk("R7 current read", d, emem[16'h1235]);

    // R8: sequential read across the top
    rd_check(16'h1FFE, 4, "R8");
    cur_read(d);
    chk("R7 current read after wrap", d, emem[2]);

    // R9: host NACK, then more clocks without Start
    i2c_start();
    send_byte(8'hA3, 0, k); chk("R9 select ack", k, 1);
    recv_byte(0, d); chk("R9 data", d, emem[3]);
    p0 = pulls;
    for (int i = 0; i < 9; i++) clk_bit(1'b1, 0, g);
    chk("R9 released after NACK", pulls, p0);
    i2c_stop();

    // R3: mismatching select codes
    i2c_start();
    send_byte(8'hA0, 0, k); chk("R3 0xA0 not acked", k, 0);
    p0 = pulls;
    send_byte(8'h00, 0, k);
    send_byte(8'hA2, 0, k); chk("R3 later byte ignored", k, 0);
    chk("R3 SDA released", pulls, p0);
    i2c_stop();
    i2c_start();
    send_byte(8'hB2, 0, k); chk("R3 0xB2 not acked", k, 0);
    i2c_stop();

    // R4/R7: multi-byte write, counter after write
    c0 = commits;
    i2c_start();
    send_byte(8'hA2, 0, k);
    send_byte(8'h01, 0, k);
    send_byte(8'h00, 0, k);
    for (int i = 0; i < 3; i++) begin
      send_byte(8'(8'h11 * (i + 1)), 0, k);
      chk("R4 page data ack", k, 1);
      emem[16'h0100 + i] = 8'(8'h11 * (i + 1));
    end
    i2c_stop();
    wt(4);
    chk("R5 one commit for page", commits, c0 + 1);
    p0 = pulls;
    i2c_start();
    send_byte(8'hA2, 0, k); chk("R10 busy select not acked", k, 0);
    i2c_stop();
    chk("R10 SDA released while busy", pulls, p0);
    poll(tries);
    cur_read(d);
    chk("R7 counter after write", d, emem[16'h0103]);
    rd_check(16'h0100, 3, "R4");

    // R5: Stop mid-byte and Stop after address give no commit
    c0 = commits;
    i2c_start();
    send_byte(8'hA2, 0, k);
    send_byte(8'h02, 0, k);
    send_byte(8'h00, 0, k);
    send_byte(8'h99, 0, k);
    for (int i = 0; i < 3; i++) clk_bit(1'b0, 0, g);
    i2c_stop();
    wt(4);
    chk("R5 no commit mid-byte", commits, c0);
    i2c_start();
    send_byte(8'hA2, 0, k);
    send_byte(8'h02, 0, k);
    send_byte(8'h10, 0, k);
    i2c_stop();
    wt(4);
    chk("R5 no commit after address", commits, c0);
    i2c_start();
    send_byte(8'hA2, 0, k); chk("R5 no write cycle started", k, 1);
    i2c_stop();

    // R11: spikes on both lines inside the address bytes
    c0 = commits;
    i2c_start();
    send_byte(8'hA2, 0, k);
    send_byte(8'h03, 1, k); chk("R11 addr hi ack with spikes", k, 1);
    send_byte(8'hFF, 1, k); chk("R11 addr lo ack with spikes", k, 1);
    send_byte(8'h4D, 0, k); chk("R11 data ack", k, 1);
    i2c_stop();
    wt(4);
    chk("R11 commit", commits, c0 + 1);
    emem[16'h03FF] = 8'h4D;
    poll(tries);
    rd_check(16'h03FF, 1, "R11");

    // R12: no pull change while SCL high
    chk("R12 pull changes only with SCL low", viol, 0);

    done = 1;
    finish_run();
  end
endmodule